// File: doc/BRIEF.md
# Conversion Flag and Interrupt Controller

This block holds one conversion-complete flag for each result slot of a multi-channel conversion sequence. It also holds a single sequence-complete flag. The converter, the compare arithmetic and the result storage sit outside the block. They report to it through per-slot done and match strobes and a sequence-done strobe. A start strobe marks the beginning of a new sequence.

Software reaches the block over a simple register bus with a select, a write strobe, an address and write data. Read data is combinational. For each slot, software chooses whether the flag tracks plain completion or a successful automatic compare. A control bit chooses how the flags are cleared:

- **Normal mode:** software writes 1 to the flag's bit.
- **Fast mode:** software touches the slot's result register. A slot without compare clears on a read. A slot with compare clears on a write.

Two level interrupt requests are produced from the registered flags:

- **Compare interrupt:** raised while any compare-enabled slot has its flag set.
- **Sequence-complete interrupt:** raised while the sequence flag is set.

Register map (word addresses):

| Address | Contents |
|---|---|
| 0 | Control. Bit 0 is fast mode, bit 1 is the compare interrupt enable, bit 2 is the sequence interrupt enable. |
| 1 | Per-slot compare enable. |
| 2 | Flag register. |
| 3 | Sequence flag, in bit 0. |
| 16 to 31 | Result register of slot n sits at address 16+n. |

Top module: `cfic_top`

## Requirements
- R1: After reset all slot flags, the sequence flag, the control bits, the compare-enable register and both interrupt outputs are 0.
- R2: For a slot whose compare-enable bit is 0, a done strobe sets its flag. For a slot whose compare-enable bit is 1, the flag is set only when the done strobe and the match strobe of that slot are both high in the same cycle.
- R3: With fast mode 0, flag n clears only on a write to address 2 with data bit n at 1. Writing 0 there, and reads or writes of result registers, leave flags unchanged.
- R4: With fast mode 1 and compare disabled for slot n, a read of address 16+n clears flag n. A write to that address does not clear it, and neither does writing 1 to address 2.
- R5: With fast mode 1 and compare enabled for slot n, a write to address 16+n clears flag n. A read of that address does not clear it, and neither does writing 1 to address 2.
- R6: A clear access aimed at slot n never changes the flag of any other slot.
- R7: When a set strobe and a clear access hit the same flag in the same cycle, the flag ends set.
- R8: The compare interrupt equals the compare interrupt enable (control bit 1) ANDed with the OR of the flags of compare-enabled slots. It falls in the cycle after the last such flag clears.
- R9: The sequence-done strobe sets the sequence flag. Writing 1 to bit 0 of address 3, or pulsing the start strobe, clears it. A set in the same cycle as a clear wins.
- R10: The sequence interrupt equals the sequence flag ANDed with the sequence interrupt enable (control bit 2).
- R11: Reads return the control bits at address 0, the compare-enable register at address 1, the flags at address 2 and the sequence flag in bit 0 of address 3. Result addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 16 | Per-slot conversion-done strobe |
| cmp_match | input | 16 | Per-slot compare-matched strobe |
| seq_done | input | 1 | Sequence-done strobe |
| seq_start | input | 1 | New-sequence start strobe |
| bus_en | input | 1 | Bus access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| flags | output | 16 | Conversion-complete flags |
| seq_flag | output | 1 | Sequence-complete flag |
| cmp_irq | output | 1 | Compare interrupt request |
| seq_irq | output | 1 | Sequence-complete interrupt request |

## Verification
The bench walks all four pairings of fast mode and per-slot compare enable. Each pairing meets each of three access kinds: a result read, a result write, and a write-one to the flag register. A design that picks the wrong clear source would either keep a flag that should drop or lose one that should stay.

After every access a neighbouring slot that is also set is checked. This catches a decoder that clears more than the addressed slot.

Same-cycle set and clear is driven for both a slot flag and the sequence flag. A clear-wins design would drop a completion there.

A compare slot that sees done without match is checked to stay clear. A non-compare flag is checked not to raise the compare interrupt.

// File: rtl/cfic_pkg.sv
package cfic_pkg;
    localparam int NSLOT = 16;
    localparam int DW    = NSLOT;
    localparam int AW    = 5;
    localparam int SW    = $clog2(NSLOT);

    localparam logic [AW-1:0] ADDR_CTRL = AW'(0);
    localparam logic [AW-1:0] ADDR_CMPE = AW'(1);
    localparam logic [AW-1:0] ADDR_FLAG = AW'(2);
    localparam logic [AW-1:0] ADDR_SEQ  = AW'(3);

    localparam int CTRL_W = 3;

    typedef struct packed {
        logic seq_ie;
        logic cmp_ie;
        logic fast;
    } ctrl_t;

    function automatic logic pick_clear(
        input logic fast,
        input logic cmpe,
        input logic rd_hit,
        input logic wr_hit,
        input logic w1c
    );
        if (!fast)
            return w1c;
        else if (cmpe)
            return wr_hit;
        else
            return rd_hit;
    endfunction

    function automatic logic pick_set(
        input logic cmpe,
        input logic done,
        input logic match
    );
        return done & (~cmpe | match);
    endfunction
endpackage

// File: rtl/cfic_regs.sv
module cfic_regs
    import cfic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic [NSLOT-1:0]     flags_i,
    input  logic                 seq_flag_i,
    output ctrl_t                ctrl_o,
    output logic [NSLOT-1:0]     cmpe_o,
    output logic [NSLOT-1:0]     clr_o,
    output logic                 seq_clr_o,
    output logic [DW-1:0]        bus_rdata
);
    logic          wr, rd, res_sel;
    logic [SW-1:0] slot_idx;

    assign wr       = bus_en & bus_we;
    assign rd       = bus_en & ~bus_we;
    assign res_sel  = bus_addr[AW-1];
    assign slot_idx = bus_addr[SW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            cmpe_o <= '0;
        end else if (wr && bus_addr == ADDR_CTRL) begin
            ctrl_o <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end else if (wr && bus_addr == ADDR_CMPE) begin
            cmpe_o <= bus_wdata;
        end
    end

    generate
        for (genvar n = 0; n < NSLOT; n++) begin : g_clr
            logic hit, rd_hit, wr_hit, w1c;
            assign hit    = res_sel && (slot_idx == SW'(n));
            assign rd_hit = rd & hit;
            assign wr_hit = wr & hit;
            assign w1c    = wr && (bus_addr == ADDR_FLAG) && bus_wdata[n];
            assign clr_o[n] = pick_clear(ctrl_o.fast, cmpe_o[n], rd_hit, wr_hit, w1c);
        end
    endgenerate

    assign seq_clr_o = wr && (bus_addr == ADDR_SEQ) && bus_wdata[0];

    always_comb begin
        bus_rdata = '0;
        if (rd && !res_sel) begin
            case (bus_addr)
                ADDR_CTRL: bus_rdata = DW'(ctrl_o);
                ADDR_CMPE: bus_rdata = cmpe_o;
                ADDR_FLAG: bus_rdata = flags_i;
                ADDR_SEQ:  bus_rdata = DW'(seq_flag_i);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R3: in normal mode a clear only comes from a flag-register write
    assert_normal_clear_src_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_o.fast && clr_o != '0) |-> (wr && bus_addr == ADDR_FLAG));

    // R4/R5: in fast mode a clear only comes from a result access
    assert_fast_clear_src_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o.fast && clr_o != '0) |-> (bus_en && res_sel));

    // R6: at most one slot clears per access in fast mode
    assert_single_slot_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_o.fast |-> $onehot0(clr_o));
endmodule

// File: rtl/cfic_flag_cell.sv
module cfic_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R7: a set always lands, even against a clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R3: a clear without a set empties the flag
    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

    // R2: a flag only rises on a set
    assert_rise_needs_set_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/cfic_irq.sv
module cfic_irq
    import cfic_pkg::*;
(
    input  ctrl_t            ctrl_i,
    input  logic [NSLOT-1:0] flags_i,
    input  logic [NSLOT-1:0] cmpe_i,
    input  logic             seq_flag_i,
    output logic             cmp_irq_o,
    output logic             seq_irq_o
);
    always_comb begin
        cmp_irq_o = ctrl_i.cmp_ie & (|(flags_i & cmpe_i));
        seq_irq_o = ctrl_i.seq_ie & seq_flag_i;
    end
endmodule

// File: rtl/cfic_top.sv
module cfic_top
    import cfic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] conv_done,
    input  logic [NSLOT-1:0] cmp_match,
    input  logic             seq_done,
    input  logic             seq_start,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic [NSLOT-1:0] flags,
    output logic             seq_flag,
    output logic             cmp_irq,
    output logic             seq_irq
);
    ctrl_t            ctrl;
    logic [NSLOT-1:0] cmpe, clr;
    logic             seq_clr;

    cfic_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .flags_i    (flags),
        .seq_flag_i (seq_flag),
        .ctrl_o     (ctrl),
        .cmpe_o     (cmpe),
        .clr_o      (clr),
        .seq_clr_o  (seq_clr),
        .bus_rdata  (bus_rdata)
    );

    generate
        for (genvar n = 0; n < NSLOT; n++) begin : g_slot
            logic set_n;
            assign set_n = pick_set(cmpe[n], conv_done[n], cmp_match[n]);
            cfic_flag_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .set_i  (set_n),
                .clr_i  (clr[n]),
                .flag_o (flags[n])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            seq_flag <= 1'b0;
        else if (seq_done)
            seq_flag <= 1'b1;
        else if (seq_clr || seq_start)
            seq_flag <= 1'b0;
    end

    cfic_irq u_irq (
        .ctrl_i     (ctrl),
        .flags_i    (flags),
        .cmpe_i     (cmpe),
        .seq_flag_i (seq_flag),
        .cmp_irq_o  (cmp_irq),
        .seq_irq_o  (seq_irq)
    );

    // R1: state is empty in the first cycle after reset
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == '0 && !seq_flag && !cmp_irq && !seq_irq));

    // R9: sequence-done always lands
    assert_seq_set_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> seq_flag);

    // R9: start without done empties the sequence flag
    assert_seq_start_R9: assert property (@(posedge clk) disable iff (rst)
        (seq_start && !seq_done) |=> !seq_flag);

    // R10: no sequence request without the flag
    assert_seq_irq_R10: assert property (@(posedge clk) disable iff (rst)
        seq_irq |-> seq_flag);

    // R8: no compare request without some compare-enabled slot set
    assert_cmp_irq_R8: assert property (@(posedge clk) disable iff (rst)
        cmp_irq |-> (flags != '0));
endmodule

// File: tb/cfic_top_tb_top.sv
module cfic_top_tb_top;
    import cfic_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NSLOT-1:0] conv_done = '0, cmp_match = '0;
    logic             seq_done = 1'b0, seq_start = 1'b0;
    logic             bus_en = 1'b0, bus_we = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [DW-1:0]    bus_wdata = '0;
    logic [DW-1:0]    bus_rdata;
    logic [NSLOT-1:0] flags;
    logic             seq_flag, cmp_irq, seq_irq;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfic_top dut_i (
        .clk(clk), .rst(rst), .conv_done(conv_done), .cmp_match(cmp_match),
        .seq_done(seq_done), .seq_start(seq_start), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .flags(flags), .seq_flag(seq_flag),
        .cmp_irq(cmp_irq), .seq_irq(seq_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pulse(input logic [NSLOT-1:0] dn, input logic [NSLOT-1:0] mt);
        conv_done = dn; cmp_match = mt;
        @(posedge clk); @(negedge clk);
        conv_done = '0; cmp_match = '0;
    endtask

    localparam logic [AW-1:0] RES5 = AW'(16 + 5);
    // entry: {fast, cmpe, access[1:0], expect_clear}; access 0=result read, 1=result write, 2=flag write-one
    localparam logic [4:0] VEC [12] = '{
        5'b0_0_00_0, 5'b0_0_01_0, 5'b0_0_10_1,
        5'b0_1_00_0, 5'b0_1_01_0, 5'b0_1_10_1,
        5'b1_0_00_1, 5'b1_0_01_0, 5'b1_0_10_0,
        5'b1_1_00_0, 5'b1_1_01_1, 5'b1_1_10_0
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 flags", 32'(flags), 0);
        check("R1 seq_flag", 32'(seq_flag), 0);
        check("R1 irqs", 32'({cmp_irq, seq_irq}), 0);
        bus_rd(ADDR_CTRL, rv); check("R1 ctrl", 32'(rv), 0);
        bus_rd(ADDR_CMPE, rv); check("R1 cmpe", 32'(rv), 0);

        // R3 R4 R5 R6 table walk on slot 5 with neighbour slot 6
        for (int i = 0; i < 12; i++) begin
            logic fast, ce, expc;
            logic [1:0] acc;
            {fast, ce, acc, expc} = VEC[i];
            bus_wr(ADDR_CTRL, 16'h0);
            bus_wr(ADDR_FLAG, 16'hFFFF);
            bus_wr(ADDR_CMPE, ce ? 16'h0060 : 16'h0000);
            pulse(16'h0060, 16'h0060);
            bus_wr(ADDR_CTRL, {15'b0, fast});
            case (acc)
                2'd0:    bus_rd(RES5, rv);
                2'd1:    bus_wr(RES5, 16'h1234);
                default: bus_wr(ADDR_FLAG, 16'h0020);
            endcase
            check(!fast ? "R3 clear rule" : (ce ? "R5 clear rule" : "R4 clear rule"),
                  32'(flags[5]), 32'(!expc));
            check("R6 neighbour kept", 32'(flags[6]), 1);
        end

        // R3 writing zeros to the flag register changes nothing
        bus_wr(ADDR_CTRL, 16'h0);
        bus_wr(ADDR_FLAG, 16'h0000);
        check("R3 zero write", 32'(flags[6]), 1);

        // R2 set rule
        bus_wr(ADDR_FLAG, 16'hFFFF);
        bus_wr(ADDR_CMPE, 16'h0001);
        pulse(16'h0003, 16'h0000);
        check("R2 no match", 32'(flags[1:0]), 32'h2);
        pulse(16'h0001, 16'h0001);
        check("R2 match", 32'(flags[1:0]), 32'h3);

        // R8 compare interrupt
        check("R8 ie off", 32'(cmp_irq), 0);
        bus_wr(ADDR_CTRL, 16'h0002);
        check("R8 ie on", 32'(cmp_irq), 1);
        bus_wr(ADDR_FLAG, 16'h0001);
        check("R8 drop after clear", 32'(cmp_irq), 0);
        check("R8 non-compare flag kept", 32'(flags[1]), 1);

        // R7 set wins over write-one clear
        bus_wr(ADDR_CTRL, 16'h0);
        pulse(16'h0008, 16'h0000);
        conv_done = 16'h0008;
        bus_wr(ADDR_FLAG, 16'h0008);
        conv_done = '0;
        check("R7 set wins", 32'(flags[3]), 1);

        // R9 R10 sequence flag and interrupt
        seq_done = 1'b1; @(posedge clk); @(negedge clk); seq_done = 1'b0;
        check("R9 set", 32'(seq_flag), 1);
        check("R10 ie off", 32'(seq_irq), 0);
        bus_wr(ADDR_CTRL, 16'h0004);
        check("R10 ie on", 32'(seq_irq), 1);
        bus_wr(ADDR_SEQ, 16'h0001);
        check("R9 write clear", 32'(seq_flag), 0);
        check("R10 drop", 32'(seq_irq), 0);
        seq_done = 1'b1; seq_start = 1'b1; @(posedge clk); @(negedge clk);
        seq_done = 1'b0; seq_start = 1'b0;
        check("R9 set wins", 32'(seq_flag), 1);
        seq_start = 1'b1; @(posedge clk); @(negedge clk); seq_start = 1'b0;
        check("R9 start clear", 32'(seq_flag), 0);

        // R11 readback
        bus_wr(ADDR_CTRL, 16'h0007);
        bus_rd(ADDR_CTRL, rv); check("R11 ctrl", 32'(rv), 32'h7);
        bus_rd(ADDR_CMPE, rv); check("R11 cmpe", 32'(rv), 32'h1);
        bus_rd(ADDR_FLAG, rv); check("R11 flags", 32'(rv), 32'(flags));
        bus_rd(AW'(16 + 9), rv); check("R11 result reads zero", 32'(rv), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule